// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a synchronous host and an asynchronous static RAM with a 20-bit address, an 8-bit shared data bus, a pair of chip selects of opposite polarity, an active-low output enable and an active-low write strobe. The host issues one read or one write at a time through a valid/ready handshake. The block then plays out the cycle on the RAM pins, phase by phase, and returns read data on its own port with a one-cycle valid pulse.

Every nanosecond limit of the RAM is a parameter. Elaboration turns each limit into a whole number of clock cycles by rounding up, and each phase is stretched until all the limits that bound it are met. The limits are write cycle, strobe width, data setup, address-to-write-end, read cycle, address access, output-enable access, and the float times after the write strobe falls and after the output enable rises. The data bus leaves the block as three ports: an output value, a drive enable and an input value, which the pad ring joins into a tristate pin.

A write keeps the output enable high. It drives data only after the RAM's outputs are sure to have floated, and it ends on the rising write strobe while both selects are still active. Data and address are therefore held across the edge that ends the write.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and whenever idle, the selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, and `req_ready`=1.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle is done, and requests presented while it is 0 have no effect on the pins.
- R3: `req_addr`, `req_wdata` and `req_write` are latched at acceptance. `mem_addr` holds through every cycle in which the RAM is selected. `mem_dq_out` holds through every cycle in which it is driven.
- R4: A write runs three phases: selects active with `mem_we_n`=1 for TA cycles, then `mem_we_n`=0 for TP cycles, then `mem_we_n`=1 with selects still active for TH cycles. After that comes idle.
- R5: `mem_dq_oe` is 1 only during a write, from the (TD+1)-th cycle of the strobe-low phase through the end of the hold phase. It is never 1 while `mem_oe_n`=0, and never within TZ cycles after the RAM last drove the bus.
- R6: `mem_oe_n` stays 1 during every write. `mem_we_n` stays 1 during every read. The two are never 0 in the same cycle.
- R7: A read holds the selects active and `mem_oe_n`=0 for TR cycles. `mem_dq_in` is sampled at the edge that ends the last of them. In the next cycle `rd_data` carries the sample, `rd_valid` is 1 for that single cycle, and `req_ready` is 1 in that same cycle.
- R8: With c(x) = ceil(x / CLK_NS) (0 when x is 0): TA = max(1, c(AS)), TH = max(1, c(DH)), TD = max(c(HZWE), c(OHZ)), TZ = c(OHZ), TP = max(c(WP), TD + max(1, c(DS)), c(AW) - TA, c(WC) - TA - TH), TR = max(1, c(AA), c(OE), c(RC)).
- R9: `mem_sel_n` is always the complement of `mem_sel`, so the RAM is selected in exactly the cycles where both are active.
- R10: A read returns the data of the most recent completed write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block can accept a request |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data to drive onto the RAM bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM bus |
| mem_dq_in | input | DATA_W | Value seen on the RAM bus |

## Verification
Every pin changes one cycle after the edge that moves the sequencer. Pin state for the first phase is therefore visible in the cycle right after the accepting edge. The read sample appears one cycle after the edge that ends the last access cycle, in the same cycle `req_ready` returns. At each accepting edge the bench's model pushes the full per-cycle pin pattern of the cycle, built from its own phase lengths. It pops one entry per edge and compares all pins at the falling edge, so every check looks at a settled, registered value. A behavioural RAM on the pins stores data on the rising write strobe and drives data only while it is read and for its float time afterwards. Read-back data and bus contention are therefore judged from what the pins really did.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC
  } asram_state_e;

  // nanoseconds to whole cycles, rounding up
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns <= 0) ? 0 : (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int T_AS  = 1,
  parameter int T_PW  = 1,
  parameter int T_DH  = 1,
  parameter int T_DRV = 0,
  parameter int T_RA  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic is_write,
  output logic sample,
  output logic nxt_sel,
  output logic nxt_we_n,
  output logic nxt_oe_n,
  output logic nxt_dq_oe,
  output logic nxt_ready
);

  localparam int T_TOP = imax(imax(imax(T_AS, T_PW), imax(T_DH, T_RA)), 1);
  localparam int CW    = $clog2(T_TOP + 1);
  localparam logic [CW-1:0] LD_AS   = CW'(T_AS - 1);
  localparam logic [CW-1:0] LD_PW   = CW'(T_PW - 1);
  localparam logic [CW-1:0] LD_DH   = CW'(T_DH - 1);
  localparam logic [CW-1:0] LD_RA   = CW'(T_RA - 1);
  localparam logic [CW-1:0] DRV_LIM = CW'(T_PW - 1 - T_DRV);

  asram_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? '0 : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (fire) begin
          state_d = is_write ? ST_WSETUP : ST_RACC;
          cnt_d   = is_write ? LD_AS : LD_RA;
        end
      end
      ST_WSETUP: if (last) begin state_d = ST_WPULSE; cnt_d = LD_PW; end
      ST_WPULSE: if (last) begin state_d = ST_WHOLD;  cnt_d = LD_DH; end
      ST_WHOLD:  if (last) state_d = ST_IDLE;
      ST_RACC:   if (last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // pin values for the cycle the next state describes
  always_comb begin
    nxt_sel   = (state_d != ST_IDLE);
    nxt_we_n  = (state_d != ST_WPULSE);
    nxt_oe_n  = (state_d != ST_RACC);
    nxt_ready = (state_d == ST_IDLE);
    nxt_dq_oe = (state_d == ST_WHOLD) ||
                ((state_d == ST_WPULSE) && (cnt_d <= DRV_LIM));
  end

  assign sample = (state_q == ST_RACC) && last;

endmodule

// File: rtl/asram_pins.sv
module asram_pins #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              nxt_sel,
  input  logic              nxt_we_n,
  input  logic              nxt_oe_n,
  input  logic              nxt_dq_oe,
  input  logic              nxt_ready,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b1;
      mem_addr   <= '0;
      mem_sel_n  <= 1'b1;
      mem_sel    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      req_ready <= nxt_ready;
      mem_sel_n <= ~nxt_sel;
      mem_sel   <= nxt_sel;
      mem_we_n  <= nxt_we_n;
      mem_oe_n  <= nxt_oe_n;
      mem_dq_oe <= nxt_dq_oe;
      if (fire) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_sel && mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r6_no_we_oe_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  a_r5_drive_needs_oe_high: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && mem_sel && !mem_sel_n));

  a_r4_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_sel && !mem_sel_n));

  a_r4_write_ends_selected: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_sel && mem_dq_oe));

  a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic [DATA_W-1:0] bus_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= bus_in;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int WC_NS   = 55,
  parameter int WP_NS   = 45,
  parameter int DS_NS   = 25,
  parameter int AW_NS   = 50,
  parameter int AS_NS   = 0,
  parameter int DH_NS   = 0,
  parameter int HZWE_NS = 30,
  parameter int RC_NS   = 55,
  parameter int AA_NS   = 55,
  parameter int OE_NS   = 30,
  parameter int OHZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int T_AS  = imax(1, ns2cyc(AS_NS, CLK_NS));
  localparam int T_DH  = imax(1, ns2cyc(DH_NS, CLK_NS));
  localparam int T_DRV = imax(ns2cyc(HZWE_NS, CLK_NS), ns2cyc(OHZ_NS, CLK_NS));
  localparam int T_PW  = imax(imax(ns2cyc(WP_NS, CLK_NS),
                                   T_DRV + imax(1, ns2cyc(DS_NS, CLK_NS))),
                              imax(ns2cyc(AW_NS, CLK_NS) - T_AS,
                                   ns2cyc(WC_NS, CLK_NS) - T_AS - T_DH));
  localparam int T_RA  = imax(imax(1, ns2cyc(AA_NS, CLK_NS)),
                              imax(ns2cyc(OE_NS, CLK_NS), ns2cyc(RC_NS, CLK_NS)));

  logic fire, sample;
  logic nxt_sel, nxt_we_n, nxt_oe_n, nxt_dq_oe, nxt_ready;

  assign fire = req_valid && req_ready;

  asram_seq #(
    .T_AS(T_AS), .T_PW(T_PW), .T_DH(T_DH), .T_DRV(T_DRV), .T_RA(T_RA)
  ) u_seq (
    .clk(clk), .rst(rst), .fire(fire), .is_write(req_write),
    .sample(sample), .nxt_sel(nxt_sel), .nxt_we_n(nxt_we_n),
    .nxt_oe_n(nxt_oe_n), .nxt_dq_oe(nxt_dq_oe), .nxt_ready(nxt_ready)
  );

  asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .fire(fire), .req_addr(req_addr), .req_wdata(req_wdata),
    .nxt_sel(nxt_sel), .nxt_we_n(nxt_we_n), .nxt_oe_n(nxt_oe_n),
    .nxt_dq_oe(nxt_dq_oe), .nxt_ready(nxt_ready), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
  );

  asram_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst(rst), .sample(sample), .bus_in(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R7: the read strobe and the return of ready land in the same cycle
  a_r7_valid_with_ready: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (req_ready && !mem_sel));

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;

  function automatic int cy(input int ns);
    if (ns == 0) return 0;
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  // R8: phase lengths from the nanosecond limits
  localparam int TA = mx(1, cy(0));
  localparam int TH = mx(1, cy(0));
  localparam int TZ = cy(20);
  localparam int TD = mx(cy(30), TZ);
  localparam int TP = mx(mx(cy(45), TD + mx(1, cy(25))), mx(cy(50) - TA, cy(55) - TA - TH));
  localparam int TR = mx(mx(1, cy(55)), mx(cy(30), cy(55)));

  typedef struct {
    bit sel; bit we_n; bit oe_n; bit dq_oe; bit ready; bit rdv;
    logic [AW-1:0] addr; logic [DW-1:0] data;
  } exp_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int tests = 0, fails = 0, cycles = 0;
  bit junk = 0;
  exp_t q[$];
  exp_t cur;
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] ram [int];
  int float_cnt = 100;
  bit prev_we_n = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // behavioural RAM on the pins
  wire ram_drv = mem_sel && !mem_sel_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = ram_drv ? (ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00) : 8'hzz;

  function automatic exp_t idle_e();
    exp_t e;
    e.sel = 0; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0; e.ready = 1; e.rdv = 0;
    e.addr = '0; e.data = '0;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: schedule pin patterns at the accepting edge
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = idle_e();
    end else begin
      if (req_valid && cur.ready) begin
        exp_t e;
        e = idle_e();
        e.ready = 0; e.sel = 1; e.addr = req_addr; e.data = req_wdata;
        if (req_write) begin
          ref_mem[int'(req_addr)] = req_wdata;
          for (int i = 0; i < TA; i++) q.push_back(e);
          e.we_n = 0;
          for (int i = 0; i < TP; i++) begin e.dq_oe = (i >= TD); q.push_back(e); end
          e.we_n = 1; e.dq_oe = 1;
          for (int i = 0; i < TH; i++) q.push_back(e);
        end else begin
          e.oe_n = 0;
          for (int i = 0; i < TR; i++) q.push_back(e);
          e = idle_e();
          e.rdv = 1;
          e.data = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
          q.push_back(e);
        end
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_e();
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(mem_sel == cur.sel, "R4", "mem_sel", mem_sel, cur.sel);
      chk(mem_sel_n == !cur.sel, "R9", "mem_sel_n", mem_sel_n, !cur.sel);
      chk(mem_we_n == cur.we_n, "R8", "mem_we_n", mem_we_n, cur.we_n);
      chk(mem_oe_n == cur.oe_n, "R6", "mem_oe_n", mem_oe_n, cur.oe_n);
      chk(mem_dq_oe == cur.dq_oe, "R5", "mem_dq_oe", mem_dq_oe, cur.dq_oe);
      chk(req_ready == cur.ready, "R2", "req_ready", req_ready, cur.ready);
      chk(rd_valid == cur.rdv, "R7", "rd_valid", rd_valid, cur.rdv);
      if (cur.sel) chk(mem_addr == cur.addr, "R3", "mem_addr", mem_addr, cur.addr);
      if (cur.dq_oe) chk(mem_dq_out == cur.data, "R3", "mem_dq_out", mem_dq_out, cur.data);
      if (cur.rdv) chk(rd_data === cur.data, "R10", "rd_data", rd_data, cur.data);
      if (mem_dq_oe) chk(float_cnt >= TZ, "R5", "contention gap", float_cnt, TZ);
      // RAM stores on the rising strobe while still selected
      if (!prev_we_n && mem_we_n && mem_sel && !mem_sel_n)
        ram[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : 8'h3c;
      float_cnt = ram_drv ? 0 : float_cnt + 1;
      prev_we_n = mem_we_n;
    end
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!cur.ready) begin
      // R2: junk presented while busy must change nothing
      req_valid = junk; req_write = ~w; req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
    end
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk(mem_sel == 0 && mem_sel_n == 1, "R1", "selects in reset", {mem_sel, mem_sel_n}, 2'b01);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "strobes in reset",
        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
    rst = 0;
    @(negedge clk);
    issue(1, 20'h00000, 8'h5a);
    issue(1, 20'hfffff, 8'hc3);
    issue(1, 20'h12345, 8'hff);
    issue(1, 20'h00001, 8'h00);
    issue(0, 20'hfffff, 8'h00);
    issue(0, 20'h00000, 8'h00);
    issue(0, 20'h12345, 8'h00);
    issue(0, 20'h54321, 8'h00);
    junk = 1;
    issue(1, 20'h0abcd, 8'h96);
    issue(0, 20'h0abcd, 8'h00);
    issue(1, 20'h00000, 8'ha7);
    issue(0, 20'h00000, 8'h00);
    for (int i = 0; i < 16; i++)
      issue(1, AW'(i * 20'h0f0f1), DW'(i * 37 + 5));
    for (int i = 15; i >= 0; i--) begin
      junk = i[0];
      issue(0, AW'(i * 20'h0f0f1), 8'h00);
    end
    junk = 0;
    repeat (TR + 4) @(negedge clk);
    chk(req_ready && !mem_sel, "R1", "idle at end", {req_ready, mem_sel}, 2'b10);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule